// File: doc/BRIEF.md
# Excluding Random Tag Generator

This block picks a 4-bit allocation tag for a 64-bit pointer and writes it into the pointer's tag field. In random mode it steps a 16-bit LFSR seed four times. The four feedback bits form an offset. Starting from the last tag held in a state word, it moves forward by that offset over the 16 tag values, wrapping from 15 to 0 and stepping over every value that an exclusion mask forbids. The returned state word carries the chosen tag and the advanced seed, so the caller can feed it back for the next request.

In adjust mode the caller supplies the tag offset directly, and the starting tag is read from the pointer itself. Only the control-register exclusion mask applies, and a signed address delta is added to the pointer. The state word is handed back unchanged. The search moves one tag value per clock, so latency depends on the offset and on the mask. A request is taken only while the block is idle, and a one-cycle done pulse marks a valid result.

Top module: `tg_top`

## Requirements
- R1: Random mode advances the seed four times. Each step computes f = s[5]^s[3]^s[2]^s[0] and forms the new seed {f, s[15:1]}. The f of step i (i = 0..3) becomes bit i of the offset. The returned seed is the seed after the fourth step.
- R2: In random mode the exclusion mask is the bitwise OR of the operand mask and the control mask. Bit k set means tag k is forbidden. The chosen tag is never a forbidden value. The tag-step input is ignored in random mode.
- R3: When all 16 mask bits are set, the chosen tag is 0. In random mode the seed still advances.
- R4: With an offset of 0, the start tag is kept if it is allowed. Otherwise the tag goes up by one, modulo 16, until an allowed value is reached.
- R5: With an offset N > 0, the tag advances N times. Each advance goes up by one, modulo 16, and passes over forbidden values.
- R6: In random mode the result state word holds the tag in bits [3:0] and the new seed in bits [23:8], with all other bits 0. Of the input state word, only bits [3:0] (start tag) and [23:8] (seed) are used.
- R7: Adjust mode (req_adjust=1) works as follows. The start tag is req_ptr[59:56] and the offset is req_tag_step. Only req_ctrl_excl forms the mask, and req_opnd_excl is ignored. res_state equals req_state.
- R8: The tag is placed in res_ptr[59:56]. The other bits equal req_ptr in random mode. In adjust mode they equal req_ptr plus the sign-extended req_addr_delta.
- R9: done is high for exactly one cycle per accepted request. A request is accepted only when busy is low. A req_valid pulse while busy is high has no effect on any later output. res_ptr and res_state change only together with done.
- R10: During and after reset, busy and done are 0 and res_ptr and res_state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_adjust | input | 1 | 1 = adjust mode, 0 = random mode |
| req_ptr | input | PTR_W | Pointer to retag |
| req_opnd_excl | input | 16 | Operand exclusion mask (random mode only) |
| req_ctrl_excl | input | 16 | Control-register exclusion mask |
| req_state | input | STATE_W | State word: last tag [3:0], seed [23:8] |
| req_tag_step | input | 4 | Explicit tag offset (adjust mode) |
| req_addr_delta | input | DELTA_W | Signed address delta (adjust mode) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_ptr | output | PTR_W | Pointer with new tag |
| res_state | output | STATE_W | Updated state word |

## Verification
A wrong seed step or a misplaced state field appears in res_state on the same done pulse as the request. That includes the seed bits returned after all-excluded requests, so a fault here does not wait for a later request. A walker that loses its remaining-step count or its captured mask shows a forbidden or shifted tag in res_ptr[59:56]. If it never reaches an allowed value, done never arrives, which the bench detects as a timeout a few dozen cycles later. A busy flag that lets a second request in produces an extra done pulse or a result that belongs to the intruding stimulus.

// File: rtl/tg_pkg.sv
// Shared constants, types and the LFSR feedback function for the tag generator.
// Assumes a 4-bit tag space and a 16-bit seed; the feedback taps are fixed.
package tg_pkg;
    localparam int TAG_W          = 4;
    localparam int NUM_TAGS       = 1 << TAG_W;
    localparam int SEED_W         = 16;
    localparam int STATE_TAG_LSB  = 0;
    localparam int STATE_SEED_LSB = 8;
    localparam int PTR_TAG_LSB    = 56;

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [NUM_TAGS-1:0] mask_t;
    typedef logic [SEED_W-1:0]   seed_t;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } wk_state_e;

    // Feedback bit taken from the current seed.
    function automatic logic seed_feedback(seed_t s);
        return s[5] ^ s[3] ^ s[2] ^ s[0];
    endfunction
endpackage

// File: rtl/tg_lfsr_offset.sv
// Advances the seed STEPS times in one combinational pass.
// Collects each feedback bit into an offset word, LSB first.
// Assumes STEPS is small (one tag width).
module tg_lfsr_offset
    import tg_pkg::*;
#(
    parameter int STEPS = TAG_W
) (
    input  seed_t              seed_in,
    output seed_t              seed_out,
    output logic [STEPS-1:0]   step_ofs
);
    // Chain of shift steps, new bit entering at the top.
    always_comb begin
        seed_t s;
        logic  fb;
        s = seed_in;
        step_ofs = '0;
        for (int i = 0; i < STEPS; i++) begin
            fb          = seed_feedback(s);
            step_ofs[i] = fb;
            s           = {fb, s[SEED_W-1:1]};
        end
        seed_out = s;
    end
endmodule

// File: rtl/tg_tag_walker.sv
// Walks the tag space one value per clock from a start tag.
// Moves by a given count of allowed values and wraps at the top.
// With a zero count it settles on the first allowed value at or after the start.
// A fully set mask gives tag 0 with no walk.
// fin pulses for one cycle while tag_out holds the result.
// Assumes start is raised only while busy is low.
module tg_tag_walker
    import tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  tag_t  start_tag,
    input  tag_t  step_cnt,
    input  mask_t excl,
    output logic  busy,
    output logic  fin,
    output tag_t  tag_out
);
    wk_state_e st;
    tag_t      cur;
    tag_t      rem;
    mask_t     msk;
    tag_t      nxt;

    // Next candidate tag, wrapping naturally in TAG_W bits.
    assign nxt = cur + tag_t'(1);

    // Walk sequencer: load on start, one step per cycle, pulse fin at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= WK_IDLE;
            cur <= '0;
            rem <= '0;
            msk <= '0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                WK_IDLE: begin
                    if (start) begin
                        msk <= excl;
                        rem <= step_cnt;
                        if (&excl) begin
                            cur <= '0;
                            fin <= 1'b1;
                        end else begin
                            cur <= start_tag;
                            st  <= WK_RUN;
                        end
                    end
                end
                WK_RUN: begin
                    if (rem == '0) begin
                        if (!msk[cur]) begin
                            fin <= 1'b1;
                            st  <= WK_IDLE;
                        end else begin
                            cur <= nxt;
                        end
                    end else begin
                        cur <= nxt;
                        if (!msk[nxt]) begin
                            rem <= rem - tag_t'(1);
                        end
                    end
                end
                default: st <= WK_IDLE;
            endcase
        end
    end

    // Status and result views.
    assign busy    = (st == WK_RUN);
    assign tag_out = cur;
endmodule

// File: rtl/tg_ptr_merge.sv
// Places a tag into a fixed field of a pointer; all other bits pass through.
// Assumes the field lies fully inside the pointer.
module tg_ptr_merge
    import tg_pkg::*;
#(
    parameter int PTR_W   = 64,
    parameter int TAG_LSB = PTR_TAG_LSB
) (
    input  logic [PTR_W-1:0] base_ptr,
    input  tag_t             tag,
    output logic [PTR_W-1:0] out_ptr
);
    localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

    // Per-bit select between the tag and the pass-through pointer bit.
    for (genvar b = 0; b < PTR_W; b++) begin : g_bit
        if (b >= TAG_LSB && b <= TAG_MSB) begin : g_tag
            assign out_ptr[b] = tag[b - TAG_LSB];
        end else begin : g_pass
            assign out_ptr[b] = base_ptr[b];
        end
    end
endmodule

// File: rtl/tg_top.sv
// Excluding tag generator top. It takes one request when idle and picks the
// start tag, offset and mask by mode. The walker runs, then the tagged pointer
// and state word are registered with a one-cycle done pulse.
// Assumes PTR_W > DELTA_W, PTR_W >= 60 and STATE_W >= 24.
module tg_top
    import tg_pkg::*;
#(
    parameter int PTR_W   = 64,
    parameter int DELTA_W = 16,
    parameter int STATE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_adjust,
    input  logic [PTR_W-1:0]   req_ptr,
    input  logic [15:0]        req_opnd_excl,
    input  logic [15:0]        req_ctrl_excl,
    input  logic [STATE_W-1:0] req_state,
    input  logic [3:0]         req_tag_step,
    input  logic [DELTA_W-1:0] req_addr_delta,
    output logic               busy,
    output logic               done,
    output logic [PTR_W-1:0]   res_ptr,
    output logic [STATE_W-1:0] res_state
);
    localparam int EXT_W = PTR_W - DELTA_W;

    logic               active;
    logic               accept;
    seed_t              seed_cur;
    seed_t              seed_adv;
    tag_t               rnd_ofs;
    tag_t               sel_start;
    tag_t               sel_step;
    mask_t              sel_mask;
    logic [PTR_W-1:0]   sel_base;
    logic               hold_adj;
    logic [PTR_W-1:0]   hold_base;
    logic [STATE_W-1:0] hold_state;
    seed_t              hold_seed;
    logic               wk_busy;
    logic               wk_fin;
    tag_t               wk_tag;
    logic [PTR_W-1:0]   merged_ptr;
    logic [STATE_W-1:0] built_state;

    // Request admission: only while no request is in flight.
    assign accept   = req_valid && !active;
    assign seed_cur = req_state[STATE_SEED_LSB +: SEED_W];

    tg_lfsr_offset #(.STEPS(TAG_W)) u_lfsr (
        .seed_in  (seed_cur),
        .seed_out (seed_adv),
        .step_ofs (rnd_ofs)
    );

    // Mode selection of start tag, offset, mask and base pointer.
    always_comb begin
        if (req_adjust) begin
            sel_start = req_ptr[PTR_TAG_LSB +: TAG_W];
            sel_step  = req_tag_step;
            sel_mask  = req_ctrl_excl;
            sel_base  = req_ptr + {{EXT_W{req_addr_delta[DELTA_W-1]}}, req_addr_delta};
        end else begin
            sel_start = req_state[STATE_TAG_LSB +: TAG_W];
            sel_step  = rnd_ofs;
            sel_mask  = req_ctrl_excl | req_opnd_excl;
            sel_base  = req_ptr;
        end
    end

    // Capture of the request context needed when the walk ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_adj   <= 1'b0;
            hold_base  <= '0;
            hold_state <= '0;
            hold_seed  <= '0;
        end else if (accept) begin
            hold_adj   <= req_adjust;
            hold_base  <= sel_base;
            hold_state <= req_state;
            hold_seed  <= seed_adv;
        end
    end

    tg_tag_walker u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_tag (sel_start),
        .step_cnt  (sel_step),
        .excl      (sel_mask),
        .busy      (wk_busy),
        .fin       (wk_fin),
        .tag_out   (wk_tag)
    );

    tg_ptr_merge #(.PTR_W(PTR_W), .TAG_LSB(PTR_TAG_LSB)) u_merge (
        .base_ptr (hold_base),
        .tag      (wk_tag),
        .out_ptr  (merged_ptr)
    );

    // Random-mode state word: tag low, seed in its field, rest zero.
    always_comb begin
        built_state = '0;
        built_state[STATE_TAG_LSB +: TAG_W]   = wk_tag;
        built_state[STATE_SEED_LSB +: SEED_W] = hold_seed;
    end

    // In-flight flag and result registers with the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            done      <= 1'b0;
            res_ptr   <= '0;
            res_state <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                active <= 1'b1;
            end else if (wk_fin) begin
                active    <= 1'b0;
                done      <= 1'b1;
                res_ptr   <= merged_ptr;
                res_state <= hold_adj ? hold_state : built_state;
            end
        end
    end

    assign busy = active;

    // The walker's own busy is implied by active; keep it observable for lint.
    logic unused_wk_busy;
    assign unused_wk_busy = wk_busy;
endmodule

// File: rtl/tg_checker.sv
// Port-level property checker for tg_top.
// It rebuilds the request context from the ports at each accepted request
// and checks the result on the done pulse.
module tg_checker #(
    parameter int PTR_W   = 64,
    parameter int DELTA_W = 16,
    parameter int STATE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_adjust,
    input logic [PTR_W-1:0]   req_ptr,
    input logic [15:0]        req_opnd_excl,
    input logic [15:0]        req_ctrl_excl,
    input logic [STATE_W-1:0] req_state,
    input logic               busy,
    input logic               done,
    input logic [PTR_W-1:0]   res_ptr,
    input logic [STATE_W-1:0] res_state
);
    logic [15:0]        cap_mask;
    logic               cap_adj;
    logic [STATE_W-1:0] cap_state;
    logic [PTR_W-1:0]   cap_ptr;
    logic [3:0]         res_tag;

    assign res_tag = res_ptr[59:56];

    // Shadow of the accepted request's context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_mask  <= '0;
            cap_adj   <= 1'b0;
            cap_state <= '0;
            cap_ptr   <= '0;
        end else if (req_valid && !busy) begin
            cap_mask  <= req_adjust ? req_ctrl_excl : (req_ctrl_excl | req_opnd_excl);
            cap_adj   <= req_adjust;
            cap_state <= req_state;
            cap_ptr   <= req_ptr;
        end
    end

    p_seed_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_adj) |-> (res_state[19:8] == cap_state[23:12]));

    p_tag_allowed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_mask != 16'hFFFF) |-> !cap_mask[res_tag]);

    p_all_excl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_mask == 16'hFFFF) |-> (res_tag == 4'h0));

    p_state_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_adj) |-> (res_state[3:0] == res_tag && res_state[7:4] == 4'h0));

    p_state_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_adj) |-> (res_state == cap_state));

    p_ptr_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_adj) |-> (res_ptr[55:0] == cap_ptr[55:0] && res_ptr[63:60] == cap_ptr[63:60]));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_ptr) |-> done);

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!done && !busy));
endmodule

bind tg_top tg_checker #(.PTR_W(PTR_W), .DELTA_W(DELTA_W), .STATE_W(STATE_W)) u_chk (.*);

// File: tb/tb_tg_top.sv
`timescale 1ns/1ps
module tb_tg_top;
    localparam logic [63:0] BASE_PTR = 64'h3B00_00C0_FFEE_1230;

    typedef struct packed {
        logic        adj;
        logic [15:0] seed;
        logic [3:0]  start;
        logic [15:0] opnd;
        logic [15:0] ctrl;
        logic [3:0]  step;
        logic [15:0] delta;
        logic [3:0]  exp_tag;
        logic [15:0] exp_seed;
    } vec_t;

    // adj seed start opnd ctrl step delta exp_tag exp_seed
    localparam vec_t VEC [0:10] = '{
        '{1'b0, 16'h0000, 4'h5, 16'h0000, 16'h0000, 4'h7, 16'h0000, 4'h5, 16'h0000}, // R4 keep, R2 step ignored
        '{1'b0, 16'h0000, 4'h5, 16'h0020, 16'h0040, 4'h0, 16'h0000, 4'h7, 16'h0000}, // R2 OR mask, R4
        '{1'b0, 16'h0000, 4'hF, 16'h8000, 16'h0003, 4'h0, 16'h0000, 4'h2, 16'h0000}, // R4 wrap
        '{1'b0, 16'h0001, 4'h3, 16'h0000, 16'h0000, 4'h0, 16'h0000, 4'h4, 16'h1000}, // R1 offset 1, R5
        '{1'b0, 16'h002D, 4'hE, 16'h8000, 16'h0000, 4'h0, 16'h0000, 4'h1, 16'h2002}, // R1 offset 2, R5 skip+wrap
        '{1'b0, 16'h000F, 4'h0, 16'h0000, 16'hAAAA, 4'h0, 16'h0000, 4'hA, 16'hD000}, // R1 offset 13, R5
        '{1'b0, 16'h000F, 4'h7, 16'hFFFF, 16'h0000, 4'h0, 16'h0000, 4'h0, 16'hD000}, // R3
        '{1'b1, 16'h1234, 4'h9, 16'h1000, 16'h0800, 4'h0, 16'h0010, 4'hC, 16'h1234}, // R7 offset 0, R8
        '{1'b1, 16'h1234, 4'h9, 16'hFFFF, 16'h2000, 4'h3, 16'hFFD0, 4'hF, 16'h1234}, // R7 step 3, R8 negative
        '{1'b1, 16'h1234, 4'h9, 16'h0000, 16'hFFFF, 4'h2, 16'h0000, 4'h0, 16'h1234}, // R3 adjust
        '{1'b0, 16'h1000, 4'h4, 16'h0000, 16'h0000, 4'h0, 16'h0000, 4'h4, 16'h0100}  // R1 R6 chained state
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_adjust = 1'b0;
    logic [63:0] req_ptr = '0;
    logic [15:0] req_opnd_excl = '0;
    logic [15:0] req_ctrl_excl = '0;
    logic [31:0] req_state = '0;
    logic [3:0]  req_tag_step = '0;
    logic [15:0] req_addr_delta = '0;
    logic        busy;
    logic        done;
    logic [63:0] res_ptr;
    logic [31:0] res_state;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tg_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_adjust(req_adjust),
        .req_ptr(req_ptr), .req_opnd_excl(req_opnd_excl), .req_ctrl_excl(req_ctrl_excl),
        .req_state(req_state), .req_tag_step(req_tag_step), .req_addr_delta(req_addr_delta),
        .busy(busy), .done(done), .res_ptr(res_ptr), .res_state(res_state)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_inputs(input vec_t v);
        req_adjust     = v.adj;
        req_ptr        = BASE_PTR;
        req_opnd_excl  = v.opnd;
        req_ctrl_excl  = v.ctrl;
        req_state      = {8'hC3, v.seed, 4'h9, v.start};
        req_tag_step   = v.step;
        req_addr_delta = v.delta;
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        set_inputs(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string req, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin
                ok = 1'b1;
                return;
            end
            @(negedge clk);
        end
        check({req, " done timeout"}, 64'd0, 64'd1);
    endtask

    function automatic logic [63:0] exp_ptr(input vec_t v);
        logic [63:0] s;
        s = v.adj ? BASE_PTR + {{48{v.delta[15]}}, v.delta} : BASE_PTR;
        s[59:56] = v.exp_tag;
        return s;
    endfunction

    function automatic logic [31:0] exp_state(input vec_t v);
        return v.adj ? {8'hC3, v.seed, 4'h9, v.start} : {8'h00, v.exp_seed, 4'h0, v.exp_tag};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        int extra;
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10 done", {63'd0, done}, 64'd0);
        check("R10 busy", {63'd0, busy}, 64'd0);
        check("R10 res_ptr", res_ptr, 64'd0);
        check("R10 res_state", {32'd0, res_state}, 64'd0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < 11; k++) begin
            issue(VEC[k]);
            wait_done($sformatf("vec%0d", k), ok);
            if (ok) begin
                check($sformatf("R8 R5 vec%0d ptr", k), res_ptr, exp_ptr(VEC[k]));
                check($sformatf("R6 R7 vec%0d state", k), {32'd0, res_state}, {32'd0, exp_state(VEC[k])});
                @(negedge clk);
                check($sformatf("R9 vec%0d pulse width", k), {63'd0, done}, 64'd0);
            end
        end

        // R9: a request while busy is ignored
        issue(VEC[5]);
        @(negedge clk);
        set_inputs(VEC[0]);
        req_valid = 1'b1;
        check("R9 busy during walk", {63'd0, busy}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done("R9 busy", ok);
        if (ok) begin
            check("R9 ignored request ptr", res_ptr, exp_ptr(VEC[5]));
            check("R9 ignored request state", {32'd0, res_state}, {32'd0, exp_state(VEC[5])});
        end
        extra = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R9 no extra done", 64'(extra), 64'd0);
        check("R9 idle after", {63'd0, busy}, 64'd0);

        // R10: reset mid-walk clears outputs
        issue(VEC[5]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 busy in reset", {63'd0, busy}, 64'd0);
        check("R10 ptr in reset", res_ptr, 64'd0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule